// File: doc/BRIEF.md
# Serial three-wire EEPROM command port

This block is the slave side of a three-wire serial memory interface that fronts a 1 kbit non-volatile array. The array is modelled here as a register file. A host selects the block with `sel`, clocks bits in on `sdin` on each rising edge of `sclk`, and receives read data or a ready/busy flag on `sdout`. The `sdout_en` output tells the pad when to drive. A strap input, `wide_org`, picks one of two shapes for the array: 128 bytes, or 64 sixteen-bit words. The page size follows the same strap.

All pins are sampled by a faster system clock through a synchroniser with edge detection, so the logic inside runs in one clock domain. Commands that change the array are only latched while `sel` is high. A self-timed program cycle of `PROG_CYCLES` system clocks starts when `sel` falls. While that cycle runs, a host that raises `sel` sees the busy level on `sdout`, and then the ready level once the cycle ends.

Top module: `uwire_mem`

## Requirements
- R1: After reset `sdout_en` is low, every array byte reads as 0xFF, and the block is write-disabled.
- R2: A frame begins with the first `sdin`=1 sampled on a rising `sclk` while `sel` is high. Zeros before it are ignored. The start bit is followed by a 2-bit opcode and then the address, both MSB first. The opcodes are: 10 read, 01 write, 11 erase, 00 control. The address is 7 bits when `wide_org`=0 and 6 bits when `wide_org`=1.
- R3: A read drives `sdout_en` high from the last address bit onward. It first presents a 0 bit, then one data bit per further rising `sclk`, MSB first: 8 bits when `wide_org`=0 and 16 bits when `wide_org`=1.
- R4: A write places its data word at the addressed location once the program cycle that starts at the following fall of `sel` has completed.
- R5: Write, erase, erase-all and write-all frames have no effect and start no program cycle unless write-enable has been issued since the last write-disable or reset.
- R6: After a program cycle starts, a host that raises `sel` sees `sdout_en`=1 and `sdout`=0 until the cycle ends, then `sdout`=1. The status stays shown until the next start bit.
- R7: Further data words clocked into the same write frame go to the following addresses. The address wraps inside a 16-byte page (byte mode, low 4 address bits) or an 8-word page (word mode, low 3 address bits). Locations in the page that were not written keep their contents.
- R8: Erase sets the addressed byte, or both bytes of the addressed word, to all ones.
- R9: While a program cycle runs, start bits are ignored, so no frame is decoded. `sdout` keeps showing busy.
- R10: In word mode, word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8.
- R11: A frame cut short by `sel` falling before its last required bit has no effect.
- R12: In a control frame, the top two address bits select the action: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all. Write-all is followed by one data word, which is then written to every location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_org | input | 1 | Strap: 0 gives 128 x 8, 1 gives 64 x 16 |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock; bits are sampled on its rising edge |
| sdin | input | 1 | Serial command, address and data input |
| sdout | output | 1 | Serial read data or ready/busy level |
| sdout_en | output | 1 | High while `sdout` must be driven |

## Verification
The bench writes a page across its upper boundary and reads back the wrapped locations and a neighbour left untouched. A design that carried the address into the next page, or that rewrote the whole page, fails there. It cuts a write frame short in the middle of its data and sends writes while disabled, then checks that no busy status appears and that the location still reads 0xFF. A block that started a cycle on a partial frame would fail both checks. It clocks a complete read frame into the block while a program cycle is running, and requires a steady busy level with no dummy bit. It also stores a word in word mode and reads it back as bytes, which catches a swapped byte order.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
package uwire_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int BYTES      = 128;
  localparam int BIDX_W     = $clog2(BYTES);
  localparam int PAGE_BYTES = 16;
  localparam int POFF_W     = $clog2(PAGE_BYTES);
  localparam int PAGES_W    = BIDX_W - POFF_W;
  localparam int CNT_W      = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {P_NONE, P_PAGE, P_ERASE, P_ERAL, P_WRAL} pend_e;
  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_RDOUT, S_DONE} fstate_e;

  function automatic int addr_len(input logic wide);
    return wide ? BIDX_W - 1 : BIDX_W;
  endfunction

  function automatic int data_len(input logic wide);
    return wide ? WORD_W : BYTE_W;
  endfunction

  // next address inside the current page, wrapping at the page edge
  function automatic logic [BIDX_W-1:0] page_step(input logic [BIDX_W-1:0] a, input logic wide);
    logic [BIDX_W-1:0] r;
    r = a;
    if (wide) r[POFF_W-2:0] = a[POFF_W-2:0] + (POFF_W-1)'(1);
    else      r[POFF_W-1:0] = a[POFF_W-1:0] + POFF_W'(1);
    return r;
  endfunction

  // value a byte takes when a program job completes
  function automatic logic [BYTE_W-1:0] commit_byte(
    input pend_e k, input logic wide, input logic [BIDX_W-1:0] bi,
    input logic [BYTE_W-1:0] old, input logic [BIDX_W-1:0] ja,
    input logic [WORD_W-1:0] jd, input logic [PAGES_W-1:0] pb,
    input logic pm, input logic [BYTE_W-1:0] pbyte);
    case (k)
      P_PAGE:  return (pm && bi[BIDX_W-1:POFF_W] == pb) ? pbyte : old;
      P_ERASE: return (wide ? (bi[BIDX_W-1:1] == ja[BIDX_W-2:0]) : (bi == ja)) ? '1 : old;
      P_ERAL:  return '1;
      P_WRAL:  return (wide && bi[0]) ? jd[WORD_W-1:BYTE_W] : jd[BYTE_W-1:0];
      default: return old;
    endcase
  endfunction
endpackage

// File: rtl/uwire_sync.sv
`timescale 1ns/1ps
module uwire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic cs_lvl,
  output logic di_lvl,
  output logic sk_rise,
  output logic cs_rise,
  output logic cs_fall
);
  logic [2:0] pipe [STAGES];
  logic [1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= {sel, sclk, sdin};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1][2:1];
    end
  end

  assign cs_lvl  = pipe[STAGES-1][2];
  assign di_lvl  = pipe[STAGES-1][0];
  assign sk_rise = pipe[STAGES-1][1] & ~prev[0];
  assign cs_rise = pipe[STAGES-1][2] & ~prev[1];
  assign cs_fall = ~pipe[STAGES-1][2] & prev[1];
endmodule

// File: rtl/uwire_frame.sv
`timescale 1ns/1ps
module uwire_frame import uwire_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              cs_lvl,
  input  logic              di_lvl,
  input  logic              sk_rise,
  input  logic              busy,
  input  logic              launch,
  input  logic [WORD_W-1:0] rd_data,
  output logic [BIDX_W-1:0] rd_addr,
  output logic              ld_ev,
  output logic [BIDX_W-1:0] ld_addr,
  output logic [WORD_W-1:0] ld_data,
  output pend_e             pend,
  output logic [BIDX_W-1:0] pend_addr,
  output logic [WORD_W-1:0] pend_data,
  output logic              sdo_val,
  output logic              sdo_oe
);
  fstate_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        opc;
  logic [BIDX_W-1:0] ash, cur;
  logic [WORD_W-1:0] dsh;
  logic [WORD_W:0]   osh;
  logic              wen, stat, wral;

  logic [BIDX_W-1:0] a_full;
  logic [WORD_W-1:0] d_full, word_in;
  logic [1:0]        ctl;
  logic              addr_last, data_last, out_last, stat_show;

  assign a_full    = {ash[BIDX_W-2:0], di_lvl};
  assign d_full    = {dsh[WORD_W-2:0], di_lvl};
  assign word_in   = wide ? d_full : {{BYTE_W{1'b0}}, d_full[BYTE_W-1:0]};
  assign ctl       = wide ? a_full[BIDX_W-2 -: 2] : a_full[BIDX_W-1 -: 2];
  assign addr_last = cnt == CNT_W'(addr_len(wide) - 1);
  assign data_last = cnt == CNT_W'(data_len(wide) - 1);
  assign out_last  = cnt == CNT_W'(data_len(wide));
  assign rd_addr   = a_full;

  assign stat_show = cs_lvl && st == S_IDLE && stat;
  assign sdo_oe    = stat_show || (cs_lvl && st == S_RDOUT);
  assign sdo_val   = stat_show ? ~busy : osh[WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; opc <= '0; ash <= '0; cur <= '0;
      dsh <= '0; osh <= '0; wen <= 1'b0; stat <= 1'b0; wral <= 1'b0;
      ld_ev <= 1'b0; ld_addr <= '0; ld_data <= '0;
      pend <= P_NONE; pend_addr <= '0; pend_data <= '0;
    end else begin
      ld_ev <= 1'b0;
      if (launch) stat <= 1'b1;
      if (!cs_lvl) begin
        st   <= S_IDLE;
        pend <= P_NONE;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di_lvl && !busy) begin
            st <= S_OPC; cnt <= '0; ash <= '0; dsh <= '0; stat <= 1'b0; wral <= 1'b0;
          end
          S_OPC: begin
            opc <= {opc[0], di_lvl};
            if (cnt == CNT_W'(1)) begin st <= S_ADDR; cnt <= '0; end
            else cnt <= cnt + CNT_W'(1);
          end
          S_ADDR: begin
            ash <= a_full;
            if (!addr_last) cnt <= cnt + CNT_W'(1);
            else begin
              cnt <= '0;
              cur <= a_full;
              case (opc)
                2'b10: begin
                  osh <= wide ? {1'b0, rd_data} : {1'b0, rd_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
                  st  <= S_RDOUT;
                end
                2'b01: st <= wen ? S_DATA : S_DONE;
                2'b11: begin
                  st <= S_DONE;
                  if (wen) begin pend <= P_ERASE; pend_addr <= a_full; end
                end
                default: case (ctl)
                  2'b11: begin wen <= 1'b1; st <= S_DONE; end
                  2'b00: begin wen <= 1'b0; st <= S_DONE; end
                  2'b10: begin st <= S_DONE; if (wen) pend <= P_ERAL; end
                  default: begin wral <= 1'b1; st <= wen ? S_DATA : S_DONE; end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dsh <= d_full;
            if (!data_last) cnt <= cnt + CNT_W'(1);
            else begin
              cnt <= '0;
              dsh <= '0;
              if (wral) begin
                pend <= P_WRAL; pend_data <= word_in; st <= S_DONE;
              end else begin
                ld_ev <= 1'b1; ld_addr <= cur; ld_data <= word_in;
                pend <= P_PAGE; pend_addr <= cur;
                cur <= page_step(cur, wide);
              end
            end
          end
          S_RDOUT: begin
            if (out_last) st <= S_DONE;
            else begin
              osh <= {osh[WORD_W-1:0], 1'b0};
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  arm_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != P_NONE) |-> wen);
  // R9
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE));
  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RDOUT) |-> (sdo_oe && !sdo_val));
  // R6
  status_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && st == S_IDLE) |-> (sdo_val == !busy));
endmodule

// File: rtl/uwire_store.sv
`timescale 1ns/1ps
module uwire_store import uwire_pkg::*; #(
  parameter int PROG_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              ld_ev,
  input  logic [BIDX_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  pend_e             pend,
  input  logic [BIDX_W-1:0] pend_addr,
  input  logic [WORD_W-1:0] pend_data,
  input  logic [BIDX_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              launch
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0]     mem  [BYTES];
  logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [PAGES_W-1:0]    pbase;
  logic [TW-1:0]         tmr;
  pend_e                 jkind;
  logic [BIDX_W-1:0]     jaddr;
  logic [WORD_W-1:0]     jdata;
  logic                  commit;
  logic [POFF_W-1:0]     woff;

  assign busy   = tmr != '0;
  assign launch = cs_fall && pend != P_NONE && !busy;
  assign commit = tmr == TW'(1);
  assign woff   = {ld_addr[POFF_W-2:0], 1'b0};

  assign rd_data = wide ? {mem[{rd_addr[BIDX_W-2:0], 1'b1}], mem[{rd_addr[BIDX_W-2:0], 1'b0}]}
                        : {{BYTE_W{1'b0}}, mem[rd_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; jkind <= P_NONE; jaddr <= '0; jdata <= '0;
    end else if (launch) begin
      tmr <= TW'(PROG_CYCLES); jkind <= pend; jaddr <= pend_addr; jdata <= pend_data;
    end else if (busy) begin
      tmr <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask <= '0;
      pbase <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (commit || (cs_rise && !busy)) begin
      pmask <= '0;
    end else if (ld_ev) begin
      if (wide) begin
        pbuf[woff]         <= ld_data[BYTE_W-1:0];
        pbuf[woff | POFF_W'(1)] <= ld_data[WORD_W-1:BYTE_W];
        pmask[woff]        <= 1'b1;
        pmask[woff | POFF_W'(1)] <= 1'b1;
        pbase <= ld_addr[BIDX_W-2:POFF_W-1];
      end else begin
        pbuf[ld_addr[POFF_W-1:0]]  <= ld_data[BYTE_W-1:0];
        pmask[ld_addr[POFF_W-1:0]] <= 1'b1;
        pbase <= ld_addr[BIDX_W-1:POFF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < BYTES; i++)
        mem[i] <= commit_byte(jkind, wide, BIDX_W'(i), mem[i], jaddr, jdata, pbase,
                              pmask[i % PAGE_BYTES], pbuf[i % PAGE_BYTES]);
    end
  end

  // R6
  busy_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));
  // R9
  page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(pmask));
endmodule

// File: rtl/uwire_mem.sv
`timescale 1ns/1ps
module uwire_mem import uwire_pkg::*; #(
  parameter int PROG_CYCLES = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_org,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_en
);
  logic              cs_lvl, di_lvl, sk_rise, cs_rise, cs_fall;
  logic              busy, launch, ld_ev;
  logic [BIDX_W-1:0] rd_addr, ld_addr, pend_addr;
  logic [WORD_W-1:0] rd_data, ld_data, pend_data;
  pend_e             pend;

  uwire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
    .cs_lvl(cs_lvl), .di_lvl(di_lvl), .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  uwire_frame u_frame (
    .clk(clk), .rst_n(rst_n), .wide(wide_org), .cs_lvl(cs_lvl), .di_lvl(di_lvl),
    .sk_rise(sk_rise), .busy(busy), .launch(launch), .rd_data(rd_data), .rd_addr(rd_addr),
    .ld_ev(ld_ev), .ld_addr(ld_addr), .ld_data(ld_data), .pend(pend),
    .pend_addr(pend_addr), .pend_data(pend_data), .sdo_val(sdout), .sdo_oe(sdout_en)
  );

  uwire_store #(.PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .wide(wide_org), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .ld_ev(ld_ev), .ld_addr(ld_addr), .ld_data(ld_data), .pend(pend),
    .pend_addr(pend_addr), .pend_data(pend_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .launch(launch)
  );
endmodule

// File: tb/uwire_mem_tb.sv
`timescale 1ns/1ps
module uwire_mem_tb;
  localparam int PROG = 600;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, wide_org = 1'b0, sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_en;
  logic obs_do, obs_oe;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uwire_mem #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide_org(wide_org), .sel(sel), .sclk(sclk),
    .sdin(sdin), .sdout(sdout), .sdout_en(sdout_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int aw();
    return wide_org ? 6 : 7;
  endfunction

  function automatic int dw();
    return wide_org ? 16 : 8;
  endfunction

  task automatic clk_bit(input logic b);
    sdin = b; tick(HALF);
    sclk = 1'b1; tick(HALF);
    obs_do = sdout; obs_oe = sdout_en;
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic raise();
    sel = 1'b1; tick(HALF);
  endtask

  task automatic drop();
    sdin = 1'b0; sclk = 1'b0; sel = 1'b0; tick(HALF);
  endtask

  task automatic rd(input int a, input int lead, output logic [15:0] v);
    raise();
    send(0, lead);
    send(3'b110, 3);
    send(a, aw());
    check("R3 dummy bit", {obs_oe, obs_do}, 2'b10);
    v = '0;
    for (int i = 0; i < dw(); i++) begin
      clk_bit(1'b0);
      v = {v[14:0], obs_do};
    end
    drop();
  endtask

  task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, 0, v);
    check(req, v, exp);
  endtask

  task automatic ctl(input logic [1:0] c);
    raise();
    send(3'b100, 3);
    send(32'(c) << (aw() - 2), aw());
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    raise();
    send(3'b101, 3);
    send(a, aw());
    send(d, dw());
    drop();
  endtask

  task automatic settle(input string req);
    int t;
    t = 0;
    raise();
    check({req, " busy level"}, {sdout_en, sdout}, 2'b10);
    while (sdout !== 1'b1 && t < 4 * PROG) begin tick(1); t++; end
    check({req, " ready level"}, {sdout_en, sdout}, 2'b11);
    check({req, " cycle length"}, 32'(t > PROG / 2 && t <= PROG), 1);
    drop();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 driver off", sdout_en, 1'b0);
    rd_chk("R1 erased byte 0", 0, 16'h00FF);
    rd(7'h7F, 2, v);
    check("R2 leading zeros skipped", v, 16'h00FF);
  endtask

  task automatic t_locked();
    wr(7'h05, 16'h3C);
    raise();
    check("R5 no cycle while disabled", sdout_en, 1'b0);
    drop();
    rd_chk("R5 byte unchanged", 7'h05, 16'h00FF);
  endtask

  task automatic t_write();
    ctl(2'b11); drop();
    wr(7'h12, 16'hA5);
    settle("R6");
    rd_chk("R4 byte written", 7'h12, 16'h00A5);
  endtask

  task automatic t_page();
    raise();
    send(3'b101, 3);
    send(7'h1E, 7);
    send(8'h11, 8); send(8'h22, 8); send(8'h33, 8); send(8'h44, 8);
    drop();
    settle("R7");
    rd_chk("R7 first", 7'h1E, 16'h11);
    rd_chk("R7 second", 7'h1F, 16'h22);
    rd_chk("R7 wrapped", 7'h10, 16'h33);
    rd_chk("R7 wrapped next", 7'h11, 16'h44);
    rd_chk("R7 neighbour kept", 7'h12, 16'hA5);
    rd_chk("R7 next page untouched", 7'h20, 16'hFF);
  endtask

  task automatic t_erase();
    raise();
    send(3'b111, 3);
    send(7'h1F, 7);
    drop();
    settle("R8");
    rd_chk("R8 erased", 7'h1F, 16'hFF);
    rd_chk("R8 other kept", 7'h1E, 16'h11);
  endtask

  task automatic t_cut();
    raise();
    send(3'b101, 3);
    send(7'h40, 7);
    send(5'b10101, 5);
    drop();
    raise();
    check("R11 no cycle after cut frame", sdout_en, 1'b0);
    drop();
    rd_chk("R11 byte unchanged", 7'h40, 16'hFF);
  endtask

  task automatic t_busy();
    int bad;
    bad = 0;
    wr(7'h50, 16'h77);
    raise();
    send(3'b110, 3);
    for (int i = 6; i >= 0; i--) begin
      clk_bit(i[0]);
      if (!(obs_oe === 1'b1 && obs_do === 1'b0)) bad++;
    end
    check("R9 frame ignored while busy", bad, 0);
    drop();
    settle("R9");
    rd_chk("R9 first write landed", 7'h50, 16'h77);
  endtask

  task automatic t_disable();
    ctl(2'b00); drop();
    wr(7'h08, 16'h11);
    raise();
    check("R5 disabled write starts nothing", sdout_en, 1'b0);
    drop();
    rd_chk("R5 disabled write lost", 7'h08, 16'hFF);
  endtask

  task automatic t_bulk();
    ctl(2'b11); drop();
    ctl(2'b01); send(8'h5A, 8); drop();
    settle("R12");
    rd_chk("R12 fill low", 0, 16'h5A);
    rd_chk("R12 fill high", 7'h7F, 16'h5A);
    rd_chk("R12 fill mid", 7'h33, 16'h5A);
    ctl(2'b10); drop();
    settle("R12");
    rd_chk("R12 clear low", 0, 16'hFF);
    rd_chk("R12 clear mid", 7'h44, 16'hFF);
  endtask

  task automatic t_word();
    wide_org = 1'b1; tick(4);
    wr(3, 16'hBEEF);
    settle("R10");
    rd_chk("R10 word read", 3, 16'hBEEF);
    wide_org = 1'b0; tick(4);
    rd_chk("R10 low byte", 6, 16'hEF);
    rd_chk("R10 high byte", 7, 16'hBE);
    wide_org = 1'b1; tick(4);
    raise();
    send(3'b111, 3); send(3, 6);
    drop();
    settle("R8");
    rd_chk("R8 word erased", 3, 16'hFFFF);
    raise();
    send(3'b101, 3); send(7, 6);
    send(16'h1234, 16); send(16'h5678, 16);
    drop();
    settle("R7");
    rd_chk("R7 word page end", 7, 16'h1234);
    rd_chk("R7 word wrapped", 0, 16'h5678);
    rd_chk("R7 word untouched", 1, 16'hFFFF);
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_locked();
    t_write();
    t_page();
    t_erase();
    t_cut();
    t_busy();
    t_disable();
    t_bulk();
    t_word();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule